// File: doc/BRIEF.md
# Timer Rate Sanity Checker

This block confirms that each of three hardware timers advances at the expected fraction of the system clock. After a start request it enables the timers one at a time, in the order 0, 1, 2. While a timer runs, the block keeps its own reference count, which is derived only from system clock cycles. The timer under test is programmed to expire when its own count reaches 100. Its input clock runs at one eighth of the system rate, so a healthy timer expires after about 800 system cycles.

When the enabled timer signals expiry, the block drops that timer's enable and compares the reference count with an inclusive acceptance window. The reference count advances by 2 once every 16 system cycles, so a healthy timer leaves it near 100. If a timer fails, the block sets that timer's own bit in an error mask. A timer that never expires is stopped by a watchdog and marked as failed. After the last timer, a done flag rises. The done flag and the mask then hold until the next start request.

Top module: `tmr_rate_check`

## Requirements
- R1: While reset is asserted, and directly after it, all timer enables, `done` and `err` are 0.
- R2: A start pulse while idle clears `err` and `done` and raises `tmr_en[0]`. Only one enable is high at a time. At the edge where timer i finishes, the enable moves to timer i+1 (for i < 2).
- R3: At the clock edge that samples expiry from the enabled timer, that timer's enable falls.
- R4: The reference count restarts from 0 for each timer. Suppose a measurement ends at the k-th edge after the edge that raised the enable. The count compared at that edge is then 2*floor((k-1)/16).
- R5: A timer passes when its compared count lies in the inclusive window 95 to 104. Any other count marks it as failed.
- R6: A failing timer sets its own bit in `err`: bit 5 (0x20) for timer 0, bit 6 (0x40) for timer 1, and bit 7 (0x80) for timer 2. Bits from several timers accumulate, and bits 0 to 4 stay 0.
- R7: If the enabled timer has not expired by the 4096th edge after its enable rose, its measurement ends at that edge. The timer is marked as failed and checking moves on.
- R8: `done` rises at the edge that ends the measurement of timer 2, with every enable low. `done` and `err` then hold until the next accepted start.
- R9: A start pulse while a measurement is in progress is ignored.
- R10: Expiry inputs of timers that are not enabled have no effect on the enables, the counting or `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check of all timers (sampled while idle) |
| tmr_exp | input | 3 | Expiry indication from each timer |
| tmr_en | output | 3 | Run enable to each timer, at most one high |
| done | output | 1 | All timers checked; holds until the next start |
| err | output | 8 | Failure mask, bits 5/6/7 for timers 0/1/2 |

## Verification
Embedded properties check the following on every cycle:
- At most one enable is high.
- Enables advance only from a timer to the next one up.
- Expiry of the enabled timer drops its enable at the next edge.
- The reference count either steps by 2 or returns to 0.
- `done` and `err` stay frozen while idle.

Some behaviour can only be shown by the bench scenarios:
- Pass and fail decisions at the window edges (ends at counts 94, 96, 104 and 106).
- Watchdog expiry.
- Accumulation of several error bits.
- Stray expiry inputs and mid-run start pulses having no effect.

For these, a behavioural model tracks the expected enables, `done` and `err` cycle by cycle.

// File: rtl/tmr_rate_check.sv
module tmr_rate_check #(
  parameter int NT        = 3,
  parameter int PHASE_CYC = 16,
  parameter int REF_STEP  = 2,
  parameter int WIN_LO    = 95,
  parameter int WIN_HI    = 104,
  parameter int WDOG      = 4096,
  parameter int ERR_LSB   = 5,
  parameter int EW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NT-1:0] tmr_exp,
  output logic [NT-1:0] tmr_en,
  output logic          done,
  output logic [EW-1:0] err
);
  localparam int PW = $clog2(PHASE_CYC);
  localparam int WW = $clog2(WDOG);
  localparam int RW = $clog2(WDOG / PHASE_CYC * REF_STEP + 1) + 1;
  localparam int IW = $clog2(NT + 1);

  logic          busy;
  logic [IW-1:0] idx;
  logic [PW-1:0] phase;
  logic [RW-1:0] ref_cnt;
  logic [WW-1:0] wd;

  wire hit     = tmr_exp[idx];
  wire timeout = (wd == WW'(WDOG - 1));
  wire finish  = busy && (hit || timeout);
  wire in_win  = (ref_cnt >= RW'(WIN_LO)) && (ref_cnt <= RW'(WIN_HI));
  wire last    = (idx == IW'(NT - 1));

  assign tmr_en = busy ? (NT'(1) << idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      phase   <= '0;
      ref_cnt <= '0;
      wd      <= '0;
      done    <= 1'b0;
      err     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        phase   <= '0;
        ref_cnt <= '0;
        wd      <= '0;
        done    <= 1'b0;
        err     <= '0;
      end
    end else if (finish) begin
      if (!hit || !in_win) err <= err | (EW'(1) << (ERR_LSB + int'(idx)));
      phase   <= '0;
      ref_cnt <= '0;
      wd      <= '0;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      wd <= wd + 1'b1;
      if (phase == PW'(PHASE_CYC - 1)) begin
        phase   <= '0;
        ref_cnt <= ref_cnt + RW'(REF_STEP);
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_en)); // R2
  AST_EN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_en) != '0 && tmr_en != '0 && tmr_en != $past(tmr_en))
      |-> (tmr_en == ($past(tmr_en) << 1))); // R2
  AST_EXP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(tmr_en & tmr_exp)) |=> ((tmr_en & $past(tmr_en)) == '0)); // R3
  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_cnt != $past(ref_cnt))
      |-> (ref_cnt == $past(ref_cnt) + RW'(REF_STEP) || ref_cnt == '0)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tmr_en == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en == '0 && !start) |=> ($stable(err) && $stable(done))); // R8
endmodule

// File: tb/tmr_rate_check_test.sv
module tmr_rate_check_test;
  localparam int WDOG = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] tmr_exp = '0;
  logic [2:0] spur = '0;
  wire  [2:0] tmr_en;
  wire        done;
  wire  [7:0] err;

  int lim [3] = '{0, 0, 0};
  int cnt [3] = '{0, 0, 0};
  int checks = 0;
  int errors = 0;

  int m_busy = 0, m_idx = 0, m_k = 0, m_done = 0, m_err = 0;

  tmr_rate_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_exp(tmr_exp),
    .tmr_en(tmr_en), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  // behavioural timers: expire after lim[i] enabled cycles (0 = never)
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (tmr_en[i]) begin
        cnt[i]++;
        tmr_exp[i] = (lim[i] != 0) && (cnt[i] >= lim[i]);
      end else begin
        cnt[i] = 0;
        tmr_exp[i] = spur[i];
      end
    end
  end

  function automatic bit fails(int k, bit exp_seen);
    int r;
    r = 2 * ((k - 1) / 16);
    return !exp_seen || r < 95 || r > 104;
  endfunction

  // reference model, one step per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_k = 0; m_done = 0; m_err = 0;
    end else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_idx = 0; m_k = 0; m_done = 0; m_err = 0;
      end
    end else begin
      m_k++;
      if (tmr_exp[m_idx] || m_k == WDOG) begin
        if (fails(m_k, tmr_exp[m_idx])) m_err |= (1 << (5 + m_idx));
        m_k = 0;
        if (m_idx == 2) begin
          m_busy = 0; m_done = 1;
        end else begin
          m_idx++;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tmr_en == 3'((m_busy != 0) ? (1 << m_idx) : 0), "R2 R3 enables", int'(tmr_en),
          (m_busy != 0) ? (1 << m_idx) : 0);
      chk(done == 1'(m_done), "R8 done", int'(done), m_done);
      chk(err == 8'(m_err), "R6 err", int'(err), m_err);
    end
  end

  function automatic int expect_mask(int a, int b, int c);
    int n [3];
    int m;
    n = '{a, b, c};
    m = 0;
    for (int i = 0; i < 3; i++) begin
      if (n[i] == 0 || n[i] > WDOG) m |= (1 << (5 + i));
      else if (fails(n[i], 1'b1)) m |= (1 << (5 + i));
    end
    return m;
  endfunction

  task automatic run(int a, int b, int c, bit poke, string tag);
    int e;
    lim = '{a, b, c};
    e = expect_mask(a, b, c);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(err == 8'(e), tag, int'(err), e);
    chk(tmr_en == 3'b000, {tag, " enables low at done"}, int'(tmr_en), 0);
    repeat (10) @(negedge clk);
    chk(done && err == 8'(e), "R8 hold after done", int'(err), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tmr_en == 3'b000 && !done && err == 8'h00, "R1 reset state",
        int'({err, done, tmr_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmr_en == 3'b000 && !done && err == 8'h00, "R1 after reset",
        int'({err, done, tmr_en}), 0);
    // R4 R5 nominal rate, all pass; R9 stray start mid-run
    run(801, 801, 801, 1'b1, "R4 R5 R9 nominal");
    // R5 lower edge: counts 94 (fail), 96 and 104 (pass); R10 stray expiries
    spur = 3'b111;
    run(768, 769, 848, 1'b0, "R5 R10 window low edge");
    spur = 3'b000;
    // R5 R6 upper edge 104 pass, 106 fail, 94 fail: mask 0xC0
    run(833, 849, 760, 1'b0, "R5 R6 window high edge");
    // R7 watchdog on timers 0 and 2: mask 0xA0
    run(0, 801, 0, 1'b0, "R7 watchdog");
    chk(expect_mask(0, 801, 0) == 8'hA0, "R6 mask bits 5 and 7", expect_mask(0, 801, 0), 8'hA0);
    // R2 restart clears the mask
    run(801, 801, 801, 1'b0, "R2 restart clears");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule